// File: doc/BRIEF.md
# Three-Phase Step Sequence Controller

This block plays a programmed series of output steps in three chained parts: a ramp-up part, a regular part and a ramp-down part. Each part has its own bank in a small step table. Each table entry holds an output value and three flags: enable, resync and ramp-down trigger. Each part also has its own step count and repetition count. A start pulse launches the run. After that, a single-cycle step strobe from an external timebase moves the controller forward. Every step lasts a programmable number of strobes.

The controller plays each non-empty part in turn. It presents the current step's value and flags, and it raises a ramp-down status while the last part runs. The output value is forced to zero on a step that is disabled or marked for resync. A downstream waveform generator can use that zero step to restart phase and frequency in step with the sequence.

The regular part can be told to repeat without end. A step flagged as ramp-down trigger in the regular part then ends it at that step's boundary. A one-cycle done pulse marks the end of the run, and the controller returns to idle.

Top module: `step_seq_ctrl`

## Requirements
- R1: After reset, out_phase is 0 (idle), out_step is 0, out_val is 0, all flag outputs, rampdown, busy and done are 0.
- R2: A start pulse in idle begins the first non-empty part, in the fixed order ramp-up (out_phase 1), regular (2), ramp-down (3), at step 0. The phase is visible on the cycle after the start edge.
- R3: The ramp-up or ramp-down part is skipped when its step count or its repetition count is 0. The regular part is skipped when its step count is 0. A skipped part takes no cycles.
- R4: A step lasts ticks_per_step step strobes, with 0 treated as 1. The step changes on the cycle after the strobe that completes it. Strobes while idle have no effect.
- R5: Within a part, steps 0 to count-1 are played in order. The whole pass is repeated the programmed number of times, and then the next non-empty part begins.
- R6: When the regular part has a repetition count of 0, it repeats without end until a ramp-down trigger step ends it.
- R7: When a regular step has its trigger flag set, the end of that step moves the run to ramp-down, or finishes the run if ramp-down is empty. The trigger flag has no effect in the ramp-up and ramp-down parts.
- R8: out_val equals the stored value when the step's enable flag is 1 and its resync flag is 0, and equals 0 otherwise. out_enable, out_resync and out_trig show the current step's flags and are 0 while idle.
- R9: rampdown is 1 exactly while out_phase is 3.
- R10: done is a one-cycle pulse with out_phase back at 0. It comes on the cycle after the strobe that completes the last step. If every part is empty, it comes on the cycle after start.
- R11: A start pulse while busy is ignored. The phase and step are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Start pulse, taken only in idle |
| step_tick | input | 1 | Single-cycle step-period strobe |
| ticks_per_step | input | TICK_W | Strobes per step (0 acts as 1) |
| up_steps | input | CNT_W | Ramp-up step count |
| up_reps | input | REP_W | Ramp-up repetition count |
| reg_steps | input | CNT_W | Regular step count |
| reg_reps | input | REP_W | Regular repetition count (0 = endless) |
| dn_steps | input | CNT_W | Ramp-down step count |
| dn_reps | input | REP_W | Ramp-down repetition count |
| wr_en | input | 1 | Table write strobe |
| wr_phase | input | 2 | Bank to write: 1 up, 2 regular, 3 down |
| wr_idx | input | IDX_W | Entry index to write |
| wr_val | input | VAL_W | Value to store |
| wr_enable | input | 1 | Enable flag to store |
| wr_resync | input | 1 | Resync flag to store |
| wr_trig | input | 1 | Ramp-down trigger flag to store |
| out_phase | output | 2 | Current part: 0 idle, 1 up, 2 regular, 3 down |
| out_step | output | IDX_W | Current step index |
| out_val | output | VAL_W | Current step value, zero-gated |
| out_enable | output | 1 | Current step enable flag |
| out_resync | output | 1 | Current step resync flag |
| out_trig | output | 1 | Current step trigger flag |
| rampdown | output | 1 | Ramp-down part active |
| busy | output | 1 | Run in progress |
| done | output | 1 | End-of-run pulse |

## Verification
The hardest situation to reach is the trigger exit from an endless regular part. Also hard is the case where a trigger flag sits in the ramp-up or ramp-down bank and must be ignored. Neither shows up in a plain counted run. The bench loads a regular bank with a repetition count of 0 and a trigger on a middle step. It places further triggers on step 0 of the ramp-up and ramp-down banks. It then steps strobe by strobe and checks each bank change. A separate endless run with no trigger shows the regular part wrapping repeatedly until reset.

// File: rtl/step_seq_pkg.sv
package step_seq_pkg;
    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_UP   = 2'd1,
        PH_REG  = 2'd2,
        PH_DN   = 2'd3
    } phase_e;

    typedef struct packed {
        logic en;
        logic resync;
        logic trig;
    } step_flags_t;
endpackage

// File: rtl/step_table.sv
module step_table #(
    parameter int VAL_W = 16,
    parameter int DEPTH = 8,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       wr_en,
    input  logic [1:0]                 wr_phase,
    input  logic [IDX_W-1:0]           wr_idx,
    input  logic [VAL_W-1:0]           wr_val,
    input  step_seq_pkg::step_flags_t  wr_flags,
    input  logic [1:0]                 rd_phase,
    input  logic [IDX_W-1:0]           rd_idx,
    output logic [VAL_W-1:0]           rd_val,
    output step_seq_pkg::step_flags_t  rd_flags
);
    import step_seq_pkg::*;

    localparam int NBANK = 3;

    logic [VAL_W-1:0] bank_val [NBANK];
    step_flags_t      bank_flg [NBANK];

    for (genvar g = 0; g < NBANK; g++) begin : g_bank
        logic [VAL_W-1:0] val_d [DEPTH];
        logic [VAL_W-1:0] val_q [DEPTH];
        step_flags_t      flg_d [DEPTH];
        step_flags_t      flg_q [DEPTH];

        always_comb begin
            for (int i = 0; i < DEPTH; i++) begin
                val_d[i] = val_q[i];
                flg_d[i] = flg_q[i];
            end
            if (wr_en && wr_phase == 2'(g + 1)) begin
                val_d[wr_idx] = wr_val;
                flg_d[wr_idx] = wr_flags;
            end
        end

        always_ff @(posedge clk) begin
            for (int i = 0; i < DEPTH; i++) begin
                if (!rst_n) begin
                    val_q[i] <= '0;
                    flg_q[i] <= '0;
                end else begin
                    val_q[i] <= val_d[i];
                    flg_q[i] <= flg_d[i];
                end
            end
        end

        assign bank_val[g] = val_q[rd_idx];
        assign bank_flg[g] = flg_q[rd_idx];
    end

    always_comb begin
        rd_val   = '0;
        rd_flags = '0;
        if (rd_phase != 2'd0) begin
            rd_val   = bank_val[rd_phase - 2'd1];
            rd_flags = bank_flg[rd_phase - 2'd1];
        end
    end
endmodule

// File: rtl/step_timer.sv
module step_timer #(
    parameter int TICK_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic              tick,
    input  logic [TICK_W-1:0] limit,
    output logic              boundary
);
    typedef struct packed {
        logic [TICK_W-1:0] cnt;
    } tmr_t;

    tmr_t              s_d, s_q;
    logic [TICK_W-1:0] last;

    always_comb begin
        last     = (limit == '0) ? '0 : limit - 1'b1;
        boundary = run && tick && (s_q.cnt >= last);
        s_d      = s_q;
        if (!run || boundary) begin
            s_d.cnt = '0;
        end else if (tick) begin
            s_d.cnt = s_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    // R4
    cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run && $stable(limit) && s_q.cnt <= last) |=> (s_q.cnt <= last));

    // R4
    idle_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> (s_q.cnt == '0));
endmodule

// File: rtl/step_fsm.sv
module step_fsm #(
    parameter int DEPTH = 8,
    parameter int REP_W = 8,
    localparam int IDX_W = $clog2(DEPTH),
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start,
    input  logic                 boundary,
    input  logic                 cur_trig,
    input  logic [CNT_W-1:0]     up_steps,
    input  logic [REP_W-1:0]     up_reps,
    input  logic [CNT_W-1:0]     reg_steps,
    input  logic [REP_W-1:0]     reg_reps,
    input  logic [CNT_W-1:0]     dn_steps,
    input  logic [REP_W-1:0]     dn_reps,
    output step_seq_pkg::phase_e phase,
    output logic [IDX_W-1:0]     idx,
    output logic                 done
);
    import step_seq_pkg::*;

    typedef struct packed {
        phase_e           phase;
        logic [IDX_W-1:0] idx;
        logic [REP_W-1:0] rep;
        logic             done;
    } fsm_t;

    fsm_t s_d, s_q;

    logic             ne_up, ne_reg, ne_dn, endless;
    logic             last_step, last_rep, leave;
    phase_e           after_idle, after_up, after_reg, nxt;
    logic [CNT_W-1:0] cur_steps;
    logic [REP_W-1:0] cur_reps;

    always_comb begin
        ne_up      = (up_steps != '0) && (up_reps != '0);
        ne_reg     = (reg_steps != '0);
        ne_dn      = (dn_steps != '0) && (dn_reps != '0);
        after_reg  = ne_dn ? PH_DN : PH_IDLE;
        after_up   = ne_reg ? PH_REG : after_reg;
        after_idle = ne_up ? PH_UP : after_up;

        unique case (s_q.phase)
            PH_UP:   begin cur_steps = up_steps;  cur_reps = up_reps;  end
            PH_REG:  begin cur_steps = reg_steps; cur_reps = reg_reps; end
            PH_DN:   begin cur_steps = dn_steps;  cur_reps = dn_reps;  end
            default: begin cur_steps = '0;        cur_reps = '0;       end
        endcase

        endless   = (s_q.phase == PH_REG) && (reg_reps == '0);
        last_step = (CNT_W'(s_q.idx) == cur_steps - 1'b1);
        last_rep  = !endless && (s_q.rep == cur_reps - 1'b1);
        leave     = ((s_q.phase == PH_REG) && cur_trig) || (last_step && last_rep);

        unique case (s_q.phase)
            PH_UP:   nxt = after_up;
            PH_REG:  nxt = after_reg;
            default: nxt = PH_IDLE;
        endcase

        s_d      = s_q;
        s_d.done = 1'b0;
        if (s_q.phase == PH_IDLE) begin
            if (start) begin
                s_d.phase = after_idle;
                s_d.idx   = '0;
                s_d.rep   = '0;
                s_d.done  = (after_idle == PH_IDLE);
            end
        end else if (boundary) begin
            if (leave) begin
                s_d.phase = nxt;
                s_d.idx   = '0;
                s_d.rep   = '0;
                s_d.done  = (nxt == PH_IDLE);
            end else if (last_step) begin
                s_d.idx = '0;
                s_d.rep = endless ? s_q.rep : s_q.rep + 1'b1;
            end else begin
                s_d.idx = s_q.idx + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '{phase: PH_IDLE, idx: '0, rep: '0, done: 1'b0};
        else        s_q <= s_d;
    end

    assign phase = s_q.phase;
    assign idx   = s_q.idx;
    assign done  = s_q.done;

    // R10
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.done |=> !s_q.done);

    // R10
    done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.done |-> (s_q.phase == PH_IDLE));

    // R2
    launch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(s_q.phase) == PH_IDLE && s_q.phase != PH_IDLE) |-> $past(start));

    // R11
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.phase != PH_IDLE && !boundary) |=> ($stable(s_q.phase) && $stable(s_q.idx)));

    // R5
    idx_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.phase != PH_IDLE && cur_steps != '0) |-> (CNT_W'(s_q.idx) < cur_steps));
endmodule

// File: rtl/step_seq_ctrl.sv
module step_seq_ctrl #(
    parameter int VAL_W  = 16,
    parameter int DEPTH  = 8,
    parameter int REP_W  = 8,
    parameter int TICK_W = 16,
    localparam int IDX_W = $clog2(DEPTH),
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              step_tick,
    input  logic [TICK_W-1:0] ticks_per_step,
    input  logic [CNT_W-1:0]  up_steps,
    input  logic [REP_W-1:0]  up_reps,
    input  logic [CNT_W-1:0]  reg_steps,
    input  logic [REP_W-1:0]  reg_reps,
    input  logic [CNT_W-1:0]  dn_steps,
    input  logic [REP_W-1:0]  dn_reps,
    input  logic              wr_en,
    input  logic [1:0]        wr_phase,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [VAL_W-1:0]  wr_val,
    input  logic              wr_enable,
    input  logic              wr_resync,
    input  logic              wr_trig,
    output logic [1:0]        out_phase,
    output logic [IDX_W-1:0]  out_step,
    output logic [VAL_W-1:0]  out_val,
    output logic              out_enable,
    output logic              out_resync,
    output logic              out_trig,
    output logic              rampdown,
    output logic              busy,
    output logic              done
);
    import step_seq_pkg::*;

    phase_e           phase;
    logic [IDX_W-1:0] idx;
    logic             boundary;
    logic [VAL_W-1:0] rd_val;
    step_flags_t      rd_flags, wr_flags;

    assign wr_flags = '{en: wr_enable, resync: wr_resync, trig: wr_trig};

    step_table #(.VAL_W(VAL_W), .DEPTH(DEPTH)) u_table (
        .clk(clk), .rst_n(rst_n),
        .wr_en(wr_en), .wr_phase(wr_phase), .wr_idx(wr_idx),
        .wr_val(wr_val), .wr_flags(wr_flags),
        .rd_phase(phase), .rd_idx(idx),
        .rd_val(rd_val), .rd_flags(rd_flags)
    );

    step_timer #(.TICK_W(TICK_W)) u_timer (
        .clk(clk), .rst_n(rst_n),
        .run(busy), .tick(step_tick), .limit(ticks_per_step),
        .boundary(boundary)
    );

    step_fsm #(.DEPTH(DEPTH), .REP_W(REP_W)) u_fsm (
        .clk(clk), .rst_n(rst_n),
        .start(start), .boundary(boundary), .cur_trig(rd_flags.trig),
        .up_steps(up_steps), .up_reps(up_reps),
        .reg_steps(reg_steps), .reg_reps(reg_reps),
        .dn_steps(dn_steps), .dn_reps(dn_reps),
        .phase(phase), .idx(idx), .done(done)
    );

    always_comb begin
        busy       = (phase != PH_IDLE);
        out_phase  = phase;
        out_step   = idx;
        rampdown   = (phase == PH_DN);
        out_enable = busy && rd_flags.en;
        out_resync = busy && rd_flags.resync;
        out_trig   = busy && rd_flags.trig;
        out_val    = (out_enable && !out_resync) ? rd_val : '0;
    end

    // R8
    zero_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!out_enable || out_resync) |-> (out_val == '0));

    // R9
    rampdown_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rampdown |-> (busy && !done));
endmodule

// File: tb/sim_step_seq_ctrl.sv
module sim_step_seq_ctrl;
    localparam int VAL_W = 16, DEPTH = 8, REP_W = 8, TICK_W = 16;
    localparam int IDX_W = $clog2(DEPTH), CNT_W = $clog2(DEPTH + 1);

    // scenario: up_steps, up_reps, reg_steps, reg_reps, dn_steps, dn_reps, ticks_per_step
    localparam int NSCN = 6;
    localparam int SCN [NSCN][7] = '{
        '{2, 1, 3, 2, 2, 1, 1},
        '{0, 1, 2, 1, 3, 2, 2},
        '{3, 2, 1, 1, 0, 1, 1},
        '{0, 0, 0, 0, 0, 0, 1},
        '{8, 1, 8, 1, 1, 3, 3},
        '{2, 0, 2, 1, 1, 1, 0}
    };

    logic clk = 0, rst_n = 0, start = 0, step_tick = 0;
    logic [TICK_W-1:0] ticks_per_step = 1;
    logic [CNT_W-1:0]  up_steps = 0, reg_steps = 0, dn_steps = 0;
    logic [REP_W-1:0]  up_reps = 0, reg_reps = 0, dn_reps = 0;
    logic wr_en = 0, wr_enable = 0, wr_resync = 0, wr_trig = 0;
    logic [1:0]        wr_phase = 0;
    logic [IDX_W-1:0]  wr_idx = 0;
    logic [VAL_W-1:0]  wr_val = 0;
    logic [1:0]        out_phase;
    logic [IDX_W-1:0]  out_step;
    logic [VAL_W-1:0]  out_val;
    logic out_enable, out_resync, out_trig, rampdown, busy, done;

    int n_chk = 0, n_bad = 0;

    always #2 clk = ~clk;

    step_seq_ctrl #(.VAL_W(VAL_W), .DEPTH(DEPTH), .REP_W(REP_W), .TICK_W(TICK_W)) u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .step_tick(step_tick),
        .ticks_per_step(ticks_per_step),
        .up_steps(up_steps), .up_reps(up_reps), .reg_steps(reg_steps), .reg_reps(reg_reps),
        .dn_steps(dn_steps), .dn_reps(dn_reps),
        .wr_en(wr_en), .wr_phase(wr_phase), .wr_idx(wr_idx), .wr_val(wr_val),
        .wr_enable(wr_enable), .wr_resync(wr_resync), .wr_trig(wr_trig),
        .out_phase(out_phase), .out_step(out_step), .out_val(out_val),
        .out_enable(out_enable), .out_resync(out_resync), .out_trig(out_trig),
        .rampdown(rampdown), .busy(busy), .done(done)
    );

    function automatic logic [VAL_W-1:0] pat(int p, int i);
        return VAL_W'(16'hA000 | (p << 8) | i);
    endfunction

    task automatic chk(string req, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wr(int p, int i, logic en, logic rs, logic tg);
        @(negedge clk);
        wr_en = 1; wr_phase = 2'(p); wr_idx = IDX_W'(i); wr_val = pat(p, i);
        wr_enable = en; wr_resync = rs; wr_trig = tg;
        @(negedge clk);
        wr_en = 0;
    endtask

    task automatic load_plain();
        for (int p = 1; p <= 3; p++)
            for (int i = 0; i < DEPTH; i++) wr(p, i, 1'b1, 1'b0, 1'b0);
    endtask

    task automatic tick();
        @(negedge clk); step_tick = 1;
        @(negedge clk); step_tick = 0;
    endtask

    task automatic go();
        @(negedge clk); start = 1;
        @(negedge clk); start = 0;
    endtask

    task automatic cfg(int su, int ru, int sr, int rr, int sd, int rd, int t);
        up_steps = CNT_W'(su);  up_reps = REP_W'(ru);
        reg_steps = CNT_W'(sr); reg_reps = REP_W'(rr);
        dn_steps = CNT_W'(sd);  dn_reps = REP_W'(rd);
        ticks_per_step = TICK_W'(t);
    endtask

    task automatic at(string req, int p, int i);
        chk({req, " phase"}, out_phase, p);
        chk({req, " step"}, out_step, i);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1 reset state
        chk("R1 phase", out_phase, 0); chk("R1 step", out_step, 0);
        chk("R1 val", out_val, 0); chk("R1 busy", busy, 0);
        chk("R1 done", done, 0); chk("R1 rampdown", rampdown, 0);
        chk("R1 flags", {out_enable, out_resync, out_trig}, 0);

        load_plain();
        // R4 strobes while idle do nothing
        tick();
        chk("R4 idle tick", out_phase, 0);

        // vector table walk: R2 R3 R5 R4 R9 R10
        for (int s = 0; s < NSCN; s++) begin
            int st [4], rp [4], eff;
            st[1] = SCN[s][0]; rp[1] = SCN[s][1];
            st[2] = SCN[s][2]; rp[2] = SCN[s][3];
            st[3] = SCN[s][4]; rp[3] = SCN[s][5];
            eff = (SCN[s][6] == 0) ? 1 : SCN[s][6];
            cfg(st[1], rp[1], st[2], rp[2], st[3], rp[3], SCN[s][6]);
            go();
            for (int p = 1; p <= 3; p++) begin
                if (st[p] == 0 || rp[p] == 0) continue;
                for (int r = 0; r < rp[p]; r++)
                    for (int i = 0; i < st[p]; i++)
                        for (int t = 0; t < eff; t++) begin
                            at("R5", p, i);
                            chk("R8 val", out_val, pat(p, i));
                            chk("R9 rampdown", rampdown, (p == 3) ? 1 : 0);
                            tick();
                        end
            end
            chk("R10 done", done, 1);
            chk("R10 idle", out_phase, 0);
            @(negedge clk);
            chk("R10 one cycle", done, 0);
        end

        // flags: R8, R11
        wr(2, 1, 1'b0, 1'b0, 1'b0);
        wr(2, 2, 1'b1, 1'b1, 1'b0);
        cfg(0, 1, 3, 1, 0, 1, 1);
        go();
        at("R3 skip up", 2, 0);
        chk("R8 plain", out_val, pat(2, 0));
        tick();
        at("R8", 2, 1);
        chk("R8 disabled val", out_val, 0);
        chk("R8 enable flag", out_enable, 0);
        tick();
        chk("R8 resync val", out_val, 0);
        chk("R8 resync flag", out_resync, 1);
        go();
        at("R11 start ignored", 2, 2);
        tick();
        chk("R10 done flags", done, 1);

        // trigger: R7, R6
        load_plain();
        wr(1, 0, 1'b1, 1'b0, 1'b1);
        wr(2, 1, 1'b1, 1'b0, 1'b1);
        wr(3, 0, 1'b1, 1'b0, 1'b1);
        cfg(2, 1, 3, 0, 2, 1, 1);
        go();
        at("R7 up", 1, 0);
        chk("R7 trig shown", out_trig, 1);
        tick();
        at("R7 up trig ignored", 1, 1);
        tick(); tick();
        at("R7 reg trig step", 2, 1);
        chk("R7 reg trig flag", out_trig, 1);
        tick();
        at("R7 jump to down", 3, 0);
        chk("R9 rampdown on", rampdown, 1);
        tick();
        at("R7 down trig ignored", 3, 1);
        tick();
        chk("R7 done", done, 1);

        // trigger with empty ramp-down finishes the run: R7
        cfg(0, 1, 3, 0, 0, 1, 1);
        go();
        tick();
        at("R7 reg", 2, 1);
        tick();
        chk("R7 finish", done, 1);
        chk("R7 finish phase", out_phase, 0);

        // endless regular without trigger: R6
        load_plain();
        cfg(0, 0, 2, 0, 1, 1, 1);
        go();
        for (int k = 0; k < 9; k++) begin
            at("R6 endless", 2, k % 2);
            tick();
        end
        chk("R6 no done", done, 0);
        @(negedge clk); rst_n = 0;
        @(negedge clk); rst_n = 1;
        @(negedge clk);
        chk("R1 reset mid-run", out_phase, 0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule